// File: doc/BRIEF.md
# Flash Command Sequencer with Status Flags

This block sits between a host register bus and a flash array. It accepts commands as a strict three-step sequence. The host first stores one aligned data word at an array address. It then writes an operation code. Finally it writes a 1 into the buffer-empty flag of the status register to launch the command. The block checks every step. A step taken out of order, or with bad content, sets a sticky access-error flag and drops the sequence. A program or erase aimed at a protected location sets a sticky protection-violation flag. While either flag is set, no new command can be launched.

Launched commands enter a two-stage pipeline: one stage executes and one waits. The host can therefore prepare the next command while the current one is still running. Each operation takes a fixed number of timebase ticks, set by parameters. The array itself is a small word memory. Erased words read all ones, and programming can only clear bits. The completion flag rises only when both pipeline stages are empty. Two interrupt requests are formed from the flags and their enable inputs.

Top module: `fcs_top`

## Requirements
- R1: After reset the status byte reads 0xC0: buffer-empty (bit 7) and complete (bit 6) are set, protection-violation (bit 5), access-error (bit 4) and blank (bit 2) are clear, and every array word reads all ones.
- R2: A valid sequence (aligned word write, code write, status write with bit 7 = 1) clears bits 7 and 6 at the launch edge. Bit 7 returns one cycle later when the pipeline has room. A program stores the bitwise AND of the old word and the new data.
- R3: Only the codes 0x05 (verify blank), 0x20 (program word), 0x40 (erase sector) and 0x41 (erase all) are accepted. Any other code sets bit 4.
- R4: A status write with bit 7 = 0 aborts the sequence and sets bit 4. Writing 1 to bit 4 or bit 5 clears that flag, and writing 0 to either leaves it unchanged. A status write with bit 7 = 1 and no complete sequence has no other effect.
- R5: An array write sets bit 4 when the divider-loaded input is low, when the byte address is odd, when the write is byte-wide, when a word is already held, or when bit 7 is clear.
- R6: A code write that does not directly follow a stored word (including a second code) sets bit 4.
- R7: A program or sector erase whose word was written with the protect input high sets bit 5, and an erase-all while the any-protection input is high sets bit 5. A verify is not affected by protection.
- R8: While bit 4 or bit 5 is set, array writes are rejected and no command launches: bits 7 and 6 stay set and the array is unchanged.
- R9: A second command can be launched while the first executes. Bit 7 stays clear while both stages are occupied.
- R10: Bit 6 sets only after both the executing and the pending command have finished. It rises one cycle after the last one completes, and bit 6 implies bit 7.
- R11: A launch clears bit 2. A verify sets bit 2 when every word reads all ones and clears it otherwise.
- R12: irq_empty equals bit 7 AND en_empty_irq, and irq_done equals bit 6 AND en_done_irq.
- R13: A sector erase sets the SECT_WORDS-aligned group of words containing the address to all ones and leaves other words unchanged. An erase-all sets every word to all ones.
- R14: An operation finishes on its Nth tick (program T_PROG, sector erase T_SERA, erase-all T_MASS, verify T_VRFY). With tick held low, nothing completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Operation timebase strobe |
| div_loaded | input | 1 | High once the timebase divider is configured |
| arr_wr | input | 1 | Array-space write strobe |
| arr_addr | input | ADDR_W | Array byte address |
| arr_data | input | DATA_W | Array write data |
| arr_byte | input | 1 | The array write is byte-wide |
| prot_hit | input | 1 | Address of the current array write is protected |
| prot_any | input | 1 | Some protection is active on the array |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Operation code |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data |
| en_empty_irq | input | 1 | Buffer-empty interrupt enable |
| en_done_irq | input | 1 | Complete interrupt enable |
| rd_idx | input | WIDX_W | Word index for array read-back |
| status | output | 8 | Status byte {empty, done, pviol, accerr, 0, blank, 0, 0} |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Complete interrupt request |
| rd_data | output | DATA_W | Registered array word at rd_idx |

## Verification
The hardest state to reach is a full pipeline. A long sector erase must still be running while a second command has already been queued behind it. Only in that window is the buffer-empty flag low with no launch in flight, and only there can the early-completion and write-while-full errors show up. The bench reaches it by launching a sector erase and then a program straight after. It makes a further array write while the erase is still running. It then measures the exact cycle at which the complete flag rises against the sum of the two operation lengths.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [7:0] OP_VERIFY = 8'h05;
  localparam logic [7:0] OP_PROG   = 8'h20;
  localparam logic [7:0] OP_SERASE = 8'h40;
  localparam logic [7:0] OP_MERASE = 8'h41;

  localparam int ST_EMPTY = 7;
  localparam int ST_DONE  = 6;
  localparam int ST_PVIOL = 5;
  localparam int ST_ACERR = 4;
  localparam int ST_BLANK = 2;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WORD, SEQ_CMD} seq_e;

  function automatic logic op_valid(input logic [7:0] c);
    return (c == OP_VERIFY) || (c == OP_PROG) || (c == OP_SERASE) || (c == OP_MERASE);
  endfunction
endpackage

// File: rtl/fcs_front.sv
module fcs_front import fcs_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  localparam int WIDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_loaded,
  input  logic              cbeif,
  input  logic              err_any,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              arr_byte,
  input  logic              prot_hit,
  input  logic              prot_any,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_code,
  input  logic              stat_wr,
  input  logic              stat_go,
  output logic              acc_evt,
  output logic              prot_evt,
  output logic              launch,
  output logic [7:0]        job_op,
  output logic [WIDX_W-1:0] job_idx,
  output logic [DATA_W-1:0] job_data
);
  seq_e seq;
  logic held_prot;
  logic arr_bad, cmd_bad, cmd_prot, abort;

  always_comb begin
    arr_bad  = arr_wr && (err_any || !div_loaded || arr_byte || arr_addr[0] ||
                          !cbeif || seq != SEQ_IDLE);
    cmd_bad  = cmd_wr && (seq != SEQ_WORD || !op_valid(cmd_code));
    cmd_prot = cmd_wr && !cmd_bad &&
               (((cmd_code == OP_PROG || cmd_code == OP_SERASE) && held_prot) ||
                (cmd_code == OP_MERASE && prot_any));
    abort    = stat_wr && !stat_go;
    acc_evt  = arr_bad || cmd_bad || abort;
    prot_evt = cmd_prot;
    launch   = stat_wr && stat_go && seq == SEQ_CMD && !err_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq       <= SEQ_IDLE;
      held_prot <= 1'b0;
      job_op    <= '0;
      job_idx   <= '0;
      job_data  <= '0;
    end else if (acc_evt || prot_evt || launch) begin
      seq <= SEQ_IDLE;
    end else if (arr_wr) begin
      seq       <= SEQ_WORD;
      held_prot <= prot_hit;
      job_idx   <= arr_addr[ADDR_W-1:1];
      job_data  <= arr_data;
    end else if (cmd_wr) begin
      seq    <= SEQ_CMD;
      job_op <= cmd_code;
    end
  end
endmodule

// File: rtl/fcs_pipe.sv
module fcs_pipe import fcs_pkg::*; #(
  parameter int WIDX_W = 6,
  parameter int DATA_W = 16,
  parameter int T_PROG = 2,
  parameter int T_SERA = 8,
  parameter int T_MASS = 12,
  parameter int T_VRFY = 4,
  localparam int T_A   = (T_PROG > T_SERA) ? T_PROG : T_SERA,
  localparam int T_B   = (T_MASS > T_VRFY) ? T_MASS : T_VRFY,
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B,
  localparam int CNT_W = $clog2(T_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              push,
  input  logic [7:0]        push_op,
  input  logic [WIDX_W-1:0] push_idx,
  input  logic [DATA_W-1:0] push_data,
  output logic              room,
  output logic              idle,
  output logic              done,
  output logic [7:0]        act_op,
  output logic [WIDX_W-1:0] act_idx,
  output logic [DATA_W-1:0] act_data
);
  logic              act_v, pend_v;
  logic [7:0]        pend_op;
  logic [WIDX_W-1:0] pend_idx;
  logic [DATA_W-1:0] pend_data;
  logic [CNT_W-1:0]  cnt, dur;

  always_comb begin
    case (act_op)
      OP_PROG:   dur = CNT_W'(T_PROG);
      OP_SERASE: dur = CNT_W'(T_SERA);
      OP_MERASE: dur = CNT_W'(T_MASS);
      default:   dur = CNT_W'(T_VRFY);
    endcase
    done = act_v && tick && (cnt == dur - CNT_W'(1));
    room = !pend_v;
    idle = !act_v && !pend_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_v <= 1'b0; pend_v <= 1'b0; cnt <= '0;
      act_op <= '0; act_idx <= '0; act_data <= '0;
      pend_op <= '0; pend_idx <= '0; pend_data <= '0;
    end else begin
      if (done) begin
        if (pend_v) begin
          act_op <= pend_op; act_idx <= pend_idx; act_data <= pend_data;
          cnt <= '0; pend_v <= 1'b0;
        end else begin
          act_v <= 1'b0;
        end
      end else if (act_v && tick) begin
        cnt <= cnt + CNT_W'(1);
      end
      if (push) begin
        if (!act_v || (done && !pend_v)) begin
          act_op <= push_op; act_idx <= push_idx; act_data <= push_data;
          act_v <= 1'b1; cnt <= '0;
        end else begin
          pend_op <= push_op; pend_idx <= push_idx; pend_data <= push_data;
          pend_v <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fcs_array.sv
module fcs_array import fcs_pkg::*; #(
  parameter int WORDS      = 64,
  parameter int SECT_WORDS = 8,
  parameter int DATA_W     = 16,
  localparam int WIDX_W    = $clog2(WORDS),
  localparam int SB        = $clog2(SECT_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_en,
  input  logic [7:0]        op,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              all_erased
);
  logic [DATA_W-1:0] mem [WORDS];

  function automatic logic [WIDX_W-1:0] sect_of(input logic [WIDX_W-1:0] w);
    return w >> SB;
  endfunction

  always_comb begin
    all_erased = 1'b1;
    for (int i = 0; i < WORDS; i++)
      if (mem[i] != '1) all_erased = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      rd_data <= '0;
    end else begin
      if (op_en) begin
        case (op)
          OP_PROG: mem[widx] <= mem[widx] & wdata;
          OP_SERASE:
            for (int i = 0; i < WORDS; i++)
              if (sect_of(WIDX_W'(i)) == sect_of(widx)) mem[i] <= '1;
          OP_MERASE:
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
          default: ;
        endcase
      end
      rd_data <= mem[rd_idx];
    end
  end
endmodule

// File: rtl/fcs_top.sv
module fcs_top import fcs_pkg::*; #(
  parameter int WORDS      = 64,
  parameter int SECT_WORDS = 8,
  parameter int DATA_W     = 16,
  parameter int T_PROG     = 2,
  parameter int T_SERA     = 8,
  parameter int T_MASS     = 12,
  parameter int T_VRFY     = 4,
  localparam int WIDX_W    = $clog2(WORDS),
  localparam int ADDR_W    = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              div_loaded,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              arr_byte,
  input  logic              prot_hit,
  input  logic              prot_any,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_code,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              en_empty_irq,
  input  logic              en_done_irq,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [7:0]        status,
  output logic              irq_empty,
  output logic              irq_done,
  output logic [DATA_W-1:0] rd_data
);
  logic cbeif, ccif, pviol, accerr, blank;
  logic acc_evt, prot_evt, launch, room, idle, done, all_erased;
  logic [7:0]        job_op, act_op;
  logic [WIDX_W-1:0] job_idx, act_idx;
  logic [DATA_W-1:0] job_data, act_data;

  fcs_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst(rst), .div_loaded(div_loaded), .cbeif(cbeif),
    .err_any(accerr || pviol), .arr_wr(arr_wr), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_byte(arr_byte), .prot_hit(prot_hit),
    .prot_any(prot_any), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .stat_wr(stat_wr), .stat_go(stat_wdata[ST_EMPTY]), .acc_evt(acc_evt),
    .prot_evt(prot_evt), .launch(launch), .job_op(job_op),
    .job_idx(job_idx), .job_data(job_data));

  fcs_pipe #(.WIDX_W(WIDX_W), .DATA_W(DATA_W), .T_PROG(T_PROG),
             .T_SERA(T_SERA), .T_MASS(T_MASS), .T_VRFY(T_VRFY)) u_pipe (
    .clk(clk), .rst(rst), .tick(tick), .push(launch), .push_op(job_op),
    .push_idx(job_idx), .push_data(job_data), .room(room), .idle(idle),
    .done(done), .act_op(act_op), .act_idx(act_idx), .act_data(act_data));

  fcs_array #(.WORDS(WORDS), .SECT_WORDS(SECT_WORDS), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst), .op_en(done), .op(act_op), .widx(act_idx),
    .wdata(act_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .all_erased(all_erased));

  always_ff @(posedge clk) begin
    if (rst) begin
      cbeif <= 1'b1; ccif <= 1'b1; pviol <= 1'b0; accerr <= 1'b0; blank <= 1'b0;
    end else begin
      if (stat_wr && stat_wdata[ST_ACERR]) accerr <= 1'b0;
      if (stat_wr && stat_wdata[ST_PVIOL]) pviol  <= 1'b0;
      if (acc_evt)  accerr <= 1'b1;
      if (prot_evt) pviol  <= 1'b1;
      if (done && act_op == OP_VERIFY) blank <= all_erased;
      if (launch) begin
        cbeif <= 1'b0; ccif <= 1'b0; blank <= 1'b0;
      end else begin
        if (!cbeif && room) cbeif <= 1'b1;
        if (!ccif && idle)  ccif  <= 1'b1;
      end
    end
  end

  always_comb begin
    status    = {cbeif, ccif, pviol, accerr, 1'b0, blank, 2'b00};
    irq_empty = cbeif && en_empty_irq;
    irq_done  = ccif && en_done_irq;
  end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker import fcs_pkg::*; (
  input logic       clk,
  input logic       rst,
  input logic [7:0] status,
  input logic       irq_empty,
  input logic       irq_done,
  input logic       en_empty_irq,
  input logic       en_done_irq,
  input logic       stat_wr,
  input logic [7:0] stat_wdata,
  input logic       cmd_wr,
  input logic [7:0] cmd_code
);
  assert_done_implies_empty_R10: assert property (@(posedge clk) disable iff (rst)
    status[ST_DONE] |-> status[ST_EMPTY]);

  assert_bad_code_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !op_valid(cmd_code)) |=> status[ST_ACERR]);

  assert_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !stat_wdata[ST_EMPTY]) |=> status[ST_ACERR]);

  assert_lockout_R8: assert property (@(posedge clk) disable iff (rst)
    (status[ST_ACERR] || status[ST_PVIOL]) |=> !$fell(status[ST_EMPTY]));

  assert_empty_gate_R12: assert property (@(posedge clk) disable iff (rst)
    !en_empty_irq |-> !irq_empty);

  assert_done_gate_R12: assert property (@(posedge clk) disable iff (rst)
    !en_done_irq |-> !irq_done);
endmodule

bind fcs_top fcs_checker u_chk (
  .clk(clk), .rst(rst), .status(status), .irq_empty(irq_empty),
  .irq_done(irq_done), .en_empty_irq(en_empty_irq), .en_done_irq(en_done_irq),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .cmd_wr(cmd_wr), .cmd_code(cmd_code));

// File: tb/tb_fcs_top.sv
`timescale 1ns/1ps
module tb_fcs_top;
  localparam int T_PROG = 2, T_SERA = 8, T_MASS = 12, T_VRFY = 4;

  logic clk = 0, rst = 1, tick = 1, div_loaded = 0;
  logic arr_wr = 0, arr_byte = 0, prot_hit = 0, prot_any = 0;
  logic [6:0] arr_addr = 0;
  logic [15:0] arr_data = 0;
  logic cmd_wr = 0, stat_wr = 0, en_empty_irq = 0, en_done_irq = 0;
  logic [7:0] cmd_code = 0, stat_wdata = 0;
  logic [5:0] rd_idx = 0;
  logic [7:0] status;
  logic irq_empty, irq_done;
  logic [15:0] rd_data;
  int checks = 0, errors = 0, cyc = 0;

  fcs_top #(.T_PROG(T_PROG), .T_SERA(T_SERA), .T_MASS(T_MASS), .T_VRFY(T_VRFY)) dut (
    .clk(clk), .rst(rst), .tick(tick), .div_loaded(div_loaded), .arr_wr(arr_wr),
    .arr_addr(arr_addr), .arr_data(arr_data), .arr_byte(arr_byte),
    .prot_hit(prot_hit), .prot_any(prot_any), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .en_empty_irq(en_empty_irq),
    .en_done_irq(en_done_irq), .rd_idx(rd_idx), .status(status),
    .irq_empty(irq_empty), .irq_done(irq_done), .rd_data(rd_data));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_arr(input logic [6:0] a, input logic [15:0] d, input logic byt, input logic ph);
    @(negedge clk); arr_wr = 1; arr_addr = a; arr_data = d; arr_byte = byt; prot_hit = ph;
    @(negedge clk); arr_wr = 0; arr_byte = 0; prot_hit = 0;
  endtask
  task automatic wr_cmd(input logic [7:0] c);
    @(negedge clk); cmd_wr = 1; cmd_code = c;
    @(negedge clk); cmd_wr = 0;
  endtask
  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); stat_wr = 1; stat_wdata = v;
    @(negedge clk); stat_wr = 0;
  endtask
  task automatic launch(input int idx, input logic [15:0] d, input logic [7:0] c, input logic ph);
    wr_arr(7'(idx * 2), d, 1'b0, ph); wr_cmd(c); wr_stat(8'h80);
  endtask
  task automatic wait_cc();
    for (int i = 0; i < 1000 && !status[6]; i++) @(negedge clk);
  endtask
  task automatic rd(input int idx, output logic [15:0] v);
    @(negedge clk); rd_idx = 6'(idx); @(negedge clk); v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 status", status, 8'hC0);
    chk("R1 irqs", {irq_empty, irq_done}, 2'b00);
    rd(63, v); chk("R1 word", v, 16'hFFFF);
  endtask

  task automatic t_divider();
    div_loaded = 0; wr_arr(7'd2, 16'h0, 1'b0, 1'b0);
    chk("R5 divider not loaded", status, 8'hD0);
    wr_stat(8'hB0); chk("R4 clear by 1", status, 8'hC0);
    div_loaded = 1;
  endtask

  task automatic t_program();
    logic [15:0] v; int c0, n;
    launch(3, 16'h1234, 8'h20, 1'b0);
    chk("R2 launch clears empty/done", status, 8'h00);
    @(negedge clk); chk("R2 empty returns", status, 8'h80);
    c0 = cyc; wait_cc(); n = cyc - c0 + 1;
    chk("R14 program tick count", 32'(n), 32'(T_PROG + 1));
    rd(3, v); chk("R2 program data", v, 16'h1234);
    launch(3, 16'hFF0F, 8'h20, 1'b0); wait_cc();
    rd(3, v); chk("R2 program ANDs", v, 16'h1204);
  endtask

  task automatic t_tick();
    logic [15:0] v;
    tick = 0; launch(4, 16'h00FF, 8'h20, 1'b0);
    repeat (20) @(negedge clk);
    chk("R14 no tick no completion", status, 8'h80);
    rd(4, v); chk("R14 word untouched", v, 16'hFFFF);
    tick = 1; wait_cc(); rd(4, v); chk("R14 completes with ticks", v, 16'h00FF);
  endtask

  task automatic t_codes();
    wr_arr(7'd8, 16'h0, 1'b0, 1'b0); wr_cmd(8'h21);
    chk("R3 invalid code", status, 8'hD0); wr_stat(8'hB0);
    wr_arr(7'd8, 16'h0, 1'b0, 1'b0); wr_cmd(8'h00);
    chk("R3 zero code", status, 8'hD0); wr_stat(8'hB0);
  endtask

  task automatic t_abort();
    wr_arr(7'd10, 16'h0, 1'b0, 1'b0); wr_cmd(8'h20); wr_stat(8'h00);
    chk("R4 abort sets accerr", status, 8'hD0);
    wr_stat(8'h80); chk("R4 write 0 to flag no effect", status, 8'hD0);
    wr_stat(8'hA0); chk("R4 clearing other flag keeps accerr", status, 8'hD0);
    wr_stat(8'h90); chk("R4 clear accerr", status, 8'hC0);
  endtask

  task automatic t_arr_err();
    wr_arr(7'd11, 16'h0, 1'b0, 1'b0); chk("R5 odd address", status, 8'hD0); wr_stat(8'hB0);
    wr_arr(7'd12, 16'h0, 1'b1, 1'b0); chk("R5 byte write", status, 8'hD0); wr_stat(8'hB0);
    wr_arr(7'd12, 16'h0, 1'b0, 1'b0); wr_arr(7'd14, 16'h0, 1'b0, 1'b0);
    chk("R5 second word", status, 8'hD0); wr_stat(8'hB0);
  endtask

  task automatic t_cmd_err();
    wr_cmd(8'h20); chk("R6 code without word", status, 8'hD0); wr_stat(8'hB0);
    wr_arr(7'd12, 16'h0, 1'b0, 1'b0); wr_cmd(8'h20); wr_cmd(8'h40);
    chk("R6 second code", status, 8'hD0); wr_stat(8'hB0);
  endtask

  task automatic t_prot();
    wr_arr(7'd12, 16'h0, 1'b0, 1'b1); wr_cmd(8'h20);
    chk("R7 protected program", status, 8'hE0); wr_stat(8'hA0);
    wr_arr(7'd12, 16'h0, 1'b0, 1'b1); wr_cmd(8'h40);
    chk("R7 protected sector erase", status, 8'hE0); wr_stat(8'hA0);
    prot_any = 1; wr_arr(7'd12, 16'h0, 1'b0, 1'b0); wr_cmd(8'h41);
    chk("R7 erase-all with protection", status, 8'hE0); wr_stat(8'hA0); prot_any = 0;
    launch(6, 16'h0, 8'h05, 1'b1); wait_cc();
    chk("R7 verify ignores protection", status, 8'hC0);
  endtask

  task automatic t_lockout();
    logic [15:0] v;
    wr_stat(8'h00);
    launch(5, 16'h0000, 8'h20, 1'b0);
    repeat (6) @(negedge clk);
    chk("R8 no launch while error", status, 8'hD0);
    rd(5, v); chk("R8 array unchanged", v, 16'hFFFF);
    wr_stat(8'hB0);
  endtask

  task automatic t_pipe();
    logic [15:0] v; int c0;
    launch(9, 16'hAAAA, 8'h20, 1'b0); wait_cc();
    launch(0, 16'h0, 8'h40, 1'b0); c0 = cyc;
    launch(10, 16'h0F0F, 8'h20, 1'b0);
    chk("R9 both stages full", status, 8'h00);
    wr_arr(7'd20, 16'h0, 1'b0, 1'b0);
    chk("R5 write while empty flag clear", status[4], 1'b1);
    while (!status[6] && cyc - c0 < 100) begin
      @(negedge clk);
    end
    chk("R10 done after both drained", 32'(cyc - c0), 32'(T_SERA + T_PROG + 1));
    wr_stat(8'hB0);
    rd(3, v);  chk("R13 sector word erased", v, 16'hFFFF);
    rd(4, v);  chk("R13 sector word erased", v, 16'hFFFF);
    rd(9, v);  chk("R13 other sector kept", v, 16'hAAAA);
    rd(10, v); chk("R9 pending program ran", v, 16'h0F0F);
  endtask

  task automatic t_blank();
    logic [15:0] v;
    launch(0, 16'h0, 8'h41, 1'b0); wait_cc();
    rd(10, v); chk("R13 erase-all", v, 16'hFFFF);
    launch(0, 16'h0, 8'h05, 1'b0); wait_cc();
    chk("R11 blank set", status, 8'hC4);
    launch(1, 16'h5555, 8'h20, 1'b0);
    chk("R11 launch clears blank", status[2], 1'b0);
    wait_cc(); launch(0, 16'h0, 8'h05, 1'b0); wait_cc();
    chk("R11 not blank", status, 8'hC0);
  endtask

  task automatic t_irq();
    en_empty_irq = 1; en_done_irq = 1; @(negedge clk);
    chk("R12 both irqs", {irq_empty, irq_done}, 2'b11);
    launch(2, 16'h1111, 8'h20, 1'b0);
    chk("R12 irqs drop at launch", {irq_empty, irq_done}, 2'b00);
    @(negedge clk); chk("R12 empty irq back", {irq_empty, irq_done}, 2'b10);
    wait_cc(); en_empty_irq = 0; @(negedge clk);
    chk("R12 gated empty irq", {irq_empty, irq_done}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst = 0; @(negedge clk);
    t_reset(); t_divider(); t_program(); t_tick(); t_codes(); t_abort();
    t_arr_err(); t_cmd_err(); t_prot(); t_lockout(); t_pipe(); t_blank(); t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule